// File: doc/BRIEF.md
# Stack and Branch Micro-Sequencer

This block is the control sequencer that carries out the memory traffic of control-transfer and stack instructions in a small 8-bit processor core with a 16-bit address space. A decoder elsewhere presents one command and a condition selector, together with the current zero and carry flags. The sequencer then runs the machine cycles of that command on one byte-wide memory port. Every cycle is one of four kinds: an operand fetch at the program counter, a load, a store, or an internal cycle with no bus access. The sequencer owns the 16-bit program counter and stack pointer.

A command is accepted only while the sequencer is idle. From the first cycle of the sequence to its last, `busy` is high. Conditional jumps and calls always consume their operand bytes. The extra internal cycle is added only when the branch is taken. A push writes the high byte first and moves downward through the stack. A return from interrupt behaves like an unconditional return and raises an interrupt-enable pulse.

Top module: `stack_branch_seq`

## Requirements
- R1: After reset, `pc` is RESET_PC (default 0x0100), `sp` is RESET_SP (default 0xFFFE), `busy` is low and both memory strobes are low.
- R2: An absolute jump (op 0) reads the target's low byte at `pc`, then its high byte at `pc`+1. If taken, `pc` becomes the target and one internal cycle follows (3 busy cycles). If not taken, `pc` advances by 2 after the two reads.
- R3: A relative jump (op 1) reads one signed byte at `pc`. If taken, `pc` becomes `pc`+1+offset and one internal cycle follows (2 busy cycles). If not taken, `pc` advances by 1 after one busy cycle.
- R4: Command codes: 0 jump, 1 relative jump, 2 call, 3 return, 4 return-from-interrupt, 5 push, 6 pop, 7 jump-to-HL. Condition codes: 0 always, 1 carry set, 2 zero set, 3 carry clear, 4 zero clear; codes 5 to 7 are never taken.
- R5: A taken call (op 2) first writes the return address (`pc`+2) low byte to `sp`-2 and high byte to `sp`-1, and `sp` drops by 2. It then reads the two target bytes at `pc` and `pc`+1, loads `pc` with the target, and ends with one internal cycle.
- R6: A call that is not taken only reads its two operand bytes, leaves `sp` unchanged and advances `pc` by 2.
- R7: A return (op 3) spends one internal check cycle. If taken, it reads the `pc` low byte at `sp` and the high byte at `sp`+1, adds 2 to `sp`, and adds one internal cycle. If not taken, it ends after the check cycle.
- R8: A return-from-interrupt (op 4) ignores the condition code, acts as a taken return, and holds `int_en` high for exactly its check cycle.
- R9: A push (op 5) writes `push_data[15:8]` to `sp`-1, then `push_data[7:0]` to `sp`-2, then adds one internal cycle. It leaves `sp` lowered by 2.
- R10: A pop (op 6) reads the low byte at `sp` and the high byte at `sp`+1. It presents them on `pop_data` and leaves `sp` raised by 2, in 2 busy cycles.
- R11: Jump-to-HL (op 7) copies `hl` into `pc` at the accepting clock edge, with no memory cycle and without raising `busy`.
- R12: `start` is ignored while `busy` is high. A command presented during a sequence changes neither the bus traffic nor `pc` or `sp`.
- R13: `mem_rd` and `mem_wr` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, taken only while idle |
| op | input | 3 | Command code |
| cond | input | 3 | Condition selector |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| hl | input | 16 | Register pair used by jump-to-HL |
| push_data | input | 16 | Value to push, captured at acceptance |
| mem_rdata | input | 8 | Read data for the current cycle's address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| pop_data | output | 16 | Last popped value |
| busy | output | 1 | High for every cycle of a running sequence |
| int_en | output | 1 | Interrupt-enable pulse from return-from-interrupt |

## Verification
The first machine cycle of a command appears on the port one clock after the edge that accepts `start`. Each further cycle follows one clock later. The updated `pc`, `sp` and `pop_data` are visible one clock after the last busy cycle, except jump-to-HL, whose `pc` is visible directly after the accepting edge. The bench's model turns each command into a queue of expected per-cycle bus records. It compares one record at every falling edge after acceptance, and compares the final state at the falling edge after the queue empties. A cycle that is missing or extra therefore shows up as a mismatch in strobes or `busy`.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int AW = 16;
    localparam int DW = 8;

    typedef enum logic [2:0] {
        OP_JP   = 3'd0,
        OP_JR   = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_RETI = 3'd4,
        OP_PUSH = 3'd5,
        OP_POP  = 3'd6,
        OP_JPHL = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_STORE_A,
        ST_STORE_B,
        ST_LOAD_LO,
        ST_LOAD_HI,
        ST_CHECK,
        ST_STALL
    } step_e;

    typedef struct packed {
        logic          rd;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } port_s;

    // condition selector: 0 always, 1 C, 2 Z, 3 !C, 4 !Z, others never
    function automatic logic cond_met(input logic [2:0] sel, input logic z, input logic c);
        case (sel)
            3'd0:    return 1'b1;
            3'd1:    return c;
            3'd2:    return z;
            3'd3:    return !c;
            3'd4:    return !z;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/sbs_cond_eval.sv
module sbs_cond_eval
    import sbs_pkg::*;
(
    input  op_e        op,
    input  logic [2:0] cond,
    input  logic       flag_z,
    input  logic       flag_c,
    output logic       taken
);
    // return-from-interrupt always behaves as unconditional
    always_comb taken = (op == OP_RETI) ? 1'b1 : cond_met(cond, flag_z, flag_c);
endmodule

// File: rtl/sbs_step_next.sv
module sbs_step_next
    import sbs_pkg::*;
(
    input  step_e step,
    input  logic  start,
    input  op_e   op_sel,
    input  logic  taken_sel,
    output step_e step_nxt
);
    always_comb begin
        step_nxt = ST_IDLE;
        case (step)
            ST_IDLE: begin
                if (start) begin
                    case (op_sel)
                        OP_JP, OP_JR:    step_nxt = ST_FETCH_LO;
                        OP_CALL:         step_nxt = taken_sel ? ST_STORE_A : ST_FETCH_LO;
                        OP_RET, OP_RETI: step_nxt = ST_CHECK;
                        OP_PUSH:         step_nxt = ST_STORE_A;
                        OP_POP:          step_nxt = ST_LOAD_LO;
                        default:         step_nxt = ST_IDLE;
                    endcase
                end
            end
            ST_FETCH_LO: begin
                if (op_sel == OP_JR) step_nxt = taken_sel ? ST_STALL : ST_IDLE;
                else                 step_nxt = ST_FETCH_HI;
            end
            ST_FETCH_HI: step_nxt = taken_sel ? ST_STALL : ST_IDLE;
            ST_STORE_A:  step_nxt = ST_STORE_B;
            ST_STORE_B:  step_nxt = (op_sel == OP_CALL) ? ST_FETCH_LO : ST_STALL;
            ST_CHECK:    step_nxt = taken_sel ? ST_LOAD_LO : ST_IDLE;
            ST_LOAD_LO:  step_nxt = ST_LOAD_HI;
            ST_LOAD_HI:  step_nxt = (op_sel == OP_POP) ? ST_IDLE : ST_STALL;
            default:     step_nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/sbs_port_drive.sv
module sbs_port_drive
    import sbs_pkg::*;
(
    input  step_e         step,
    input  op_e           op_q,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] sp,
    input  logic [15:0]   push_q,
    output port_s         port,
    output logic          int_en
);
    logic [AW-1:0] ret_addr;
    logic          is_call;

    always_comb begin
        ret_addr = pc + AW'(2);
        is_call  = (op_q == OP_CALL);
        port     = '0;
        int_en   = 1'b0;
        case (step)
            ST_FETCH_LO, ST_FETCH_HI: begin
                port.rd   = 1'b1;
                port.addr = pc;
            end
            ST_STORE_A: begin
                port.wr    = 1'b1;
                port.addr  = is_call ? sp - AW'(2) : sp - AW'(1);
                port.wdata = is_call ? ret_addr[7:0] : push_q[15:8];
            end
            ST_STORE_B: begin
                port.wr    = 1'b1;
                port.addr  = is_call ? sp + AW'(1) : sp - AW'(1);
                port.wdata = is_call ? ret_addr[15:8] : push_q[7:0];
            end
            ST_LOAD_LO: begin
                port.rd   = 1'b1;
                port.addr = sp;
            end
            ST_LOAD_HI: begin
                port.rd   = 1'b1;
                port.addr = (op_q == OP_POP) ? sp : sp + AW'(1);
            end
            ST_CHECK: int_en = (op_q == OP_RETI);
            default: ;
        endcase
    end
endmodule

// File: rtl/stack_branch_seq.sv
module stack_branch_seq
    import sbs_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0100,
    parameter logic [15:0] RESET_SP = 16'hFFFE
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [2:0]  op,
    input  logic [2:0]  cond,
    input  logic        flag_z,
    input  logic        flag_c,
    input  logic [15:0] hl,
    input  logic [15:0] push_data,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [15:0] pc,
    output logic [15:0] sp,
    output logic [15:0] pop_data,
    output logic        busy,
    output logic        int_en
);
    step_e      step_q, step_nxt;
    op_e        op_q, op_in, op_sel;
    logic       taken_q, taken_in, taken_sel;
    logic [7:0] lo_q;
    logic [15:0] push_q;
    port_s      port;

    assign op_in     = op_e'(op);
    assign op_sel    = (step_q == ST_IDLE) ? op_in : op_q;
    assign taken_sel = (step_q == ST_IDLE) ? taken_in : taken_q;

    sbs_cond_eval u_cond (
        .op(op_in), .cond(cond), .flag_z(flag_z), .flag_c(flag_c), .taken(taken_in)
    );

    sbs_step_next u_next (
        .step(step_q), .start(start), .op_sel(op_sel), .taken_sel(taken_sel), .step_nxt(step_nxt)
    );

    sbs_port_drive u_port (
        .step(step_q), .op_q(op_q), .pc(pc), .sp(sp), .push_q(push_q), .port(port), .int_en(int_en)
    );

    assign mem_rd    = port.rd;
    assign mem_wr    = port.wr;
    assign mem_addr  = port.addr;
    assign mem_wdata = port.wdata;
    assign busy      = (step_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q   <= ST_IDLE;
            op_q     <= OP_JP;
            taken_q  <= 1'b0;
            lo_q     <= '0;
            push_q   <= '0;
            pc       <= RESET_PC;
            sp       <= RESET_SP;
            pop_data <= '0;
        end else begin
            step_q <= step_nxt;
            case (step_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q    <= op_in;
                        taken_q <= taken_in;
                        push_q  <= push_data;
                        if (op_in == OP_JPHL) pc <= hl;
                    end
                end
                ST_FETCH_LO: begin
                    lo_q <= mem_rdata;
                    if (op_q == OP_JR && taken_q)
                        pc <= pc + 16'd1 + {{8{mem_rdata[7]}}, mem_rdata};
                    else
                        pc <= pc + 16'd1;
                end
                ST_FETCH_HI: pc <= taken_q ? {mem_rdata, lo_q} : pc + 16'd1;
                ST_STORE_A:  sp <= (op_q == OP_CALL) ? sp - 16'd2 : sp - 16'd1;
                ST_STORE_B:  if (op_q == OP_PUSH) sp <= sp - 16'd1;
                ST_LOAD_LO: begin
                    lo_q <= mem_rdata;
                    if (op_q == OP_POP) sp <= sp + 16'd1;
                end
                ST_LOAD_HI: begin
                    if (op_q == OP_POP) begin
                        sp       <= sp + 16'd1;
                        pop_data <= {mem_rdata, lo_q};
                    end else begin
                        pc <= {mem_rdata, lo_q};
                        sp <= sp + 16'd2;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [2:0]  op,
    input logic [15:0] hl,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [15:0] pc,
    input logic        busy,
    input logic        int_en
);
    // R13: strobes exclusive
    p_rw_exclusive_r13: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !mem_wr);

    // R13: no bus access while idle
    p_strobe_busy_r13: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> busy);

    // R12: idle with no request stays idle
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);

    // R11: jump-to-HL completes at the accepting edge
    p_jphl_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && op == 3'd7) |=> (pc == $past(hl) && !busy));

    // R5 and R9: stores never move the program counter
    p_store_pc_r9: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> $stable(pc));

    // R8: interrupt-enable pulse only in an internal busy cycle
    p_int_en_r8: assert property (@(posedge clk) disable iff (rst)
        int_en |-> (busy && !mem_rd && !mem_wr));
endmodule

bind stack_branch_seq sbs_checker u_chk (
    .clk(clk), .rst(rst), .start(start), .op(op), .hl(hl),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .pc(pc), .busy(busy), .int_en(int_en)
);

// File: tb/stack_branch_seq_tb.sv
module stack_branch_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [2:0]  cond = 3'd0;
    logic        flag_z = 1'b0;
    logic        flag_c = 1'b0;
    logic [15:0] hl = 16'h0000;
    logic [15:0] push_data = 16'h0000;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr, pc, sp, pop_data;
    logic [7:0]  mem_wdata;
    logic        mem_rd, mem_wr, busy, int_en;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    typedef struct {
        bit          rd;
        bit          wr;
        bit          ie;
        logic [15:0] a;
        logic [7:0]  d;
    } rec_t;

    rec_t exp_q[$];
    logic [15:0] m_pc, m_sp, m_pop;

    always #2 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    assign mem_rdata = memf(mem_addr);

    stack_branch_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .cond(cond),
        .flag_z(flag_z), .flag_c(flag_c), .hl(hl), .push_data(push_data),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .pc(pc), .sp(sp), .pop_data(pop_data),
        .busy(busy), .int_en(int_en)
    );

    function automatic bit cond_ok(input logic [2:0] s, input logic z, input logic c);
        case (s)
            3'd0: return 1;
            3'd1: return c;
            3'd2: return z;
            3'd3: return !c;
            3'd4: return !z;
            default: return 0;
        endcase
    endfunction

    function automatic rec_t mk(input bit rd, input bit wr, input bit ie,
                                input logic [15:0] a, input logic [7:0] d);
        rec_t r;
        r.rd = rd; r.wr = wr; r.ie = ie; r.a = a; r.d = d;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // builds the expected per-cycle records and final state (R2..R10)
    task automatic model(input logic [2:0] o, input logic [2:0] cs, input logic z,
                         input logic c, input logic [15:0] hv, input logic [15:0] pd);
        bit tk;
        logic [15:0] t;
        tk = (o == 3'd4) ? 1'b1 : cond_ok(cs, z, c);
        exp_q.delete();
        case (o)
            3'd0: begin
                exp_q.push_back(mk(1, 0, 0, m_pc, 0));
                exp_q.push_back(mk(1, 0, 0, m_pc + 16'd1, 0));
                if (tk) begin
                    exp_q.push_back(mk(0, 0, 0, 0, 0));
                    m_pc = {memf(m_pc + 16'd1), memf(m_pc)};
                end else m_pc = m_pc + 16'd2;
            end
            3'd1: begin
                exp_q.push_back(mk(1, 0, 0, m_pc, 0));
                if (tk) begin
                    exp_q.push_back(mk(0, 0, 0, 0, 0));
                    t = {{8{memf(m_pc)[7]}}, memf(m_pc)};
                    m_pc = m_pc + 16'd1 + t;
                end else m_pc = m_pc + 16'd1;
            end
            3'd2: begin
                if (tk) begin
                    t = m_pc + 16'd2;
                    exp_q.push_back(mk(0, 1, 0, m_sp - 16'd2, t[7:0]));
                    exp_q.push_back(mk(0, 1, 0, m_sp - 16'd1, t[15:8]));
                    m_sp = m_sp - 16'd2;
                end
                exp_q.push_back(mk(1, 0, 0, m_pc, 0));
                exp_q.push_back(mk(1, 0, 0, m_pc + 16'd1, 0));
                if (tk) begin
                    exp_q.push_back(mk(0, 0, 0, 0, 0));
                    m_pc = {memf(m_pc + 16'd1), memf(m_pc)};
                end else m_pc = m_pc + 16'd2;
            end
            3'd3, 3'd4: begin
                exp_q.push_back(mk(0, 0, (o == 3'd4), 0, 0));
                if (tk) begin
                    exp_q.push_back(mk(1, 0, 0, m_sp, 0));
                    exp_q.push_back(mk(1, 0, 0, m_sp + 16'd1, 0));
                    exp_q.push_back(mk(0, 0, 0, 0, 0));
                    m_pc = {memf(m_sp + 16'd1), memf(m_sp)};
                    m_sp = m_sp + 16'd2;
                end
            end
            3'd5: begin
                exp_q.push_back(mk(0, 1, 0, m_sp - 16'd1, pd[15:8]));
                exp_q.push_back(mk(0, 1, 0, m_sp - 16'd2, pd[7:0]));
                exp_q.push_back(mk(0, 0, 0, 0, 0));
                m_sp = m_sp - 16'd2;
            end
            3'd6: begin
                exp_q.push_back(mk(1, 0, 0, m_sp, 0));
                exp_q.push_back(mk(1, 0, 0, m_sp + 16'd1, 0));
                m_pop = {memf(m_sp + 16'd1), memf(m_sp)};
                m_sp = m_sp + 16'd2;
            end
            default: m_pc = hv;
        endcase
    endtask

    task automatic run(input logic [2:0] o, input logic [2:0] cs, input logic z,
                       input logic c, input logic [15:0] hv, input logic [15:0] pd,
                       input bit hold, input string req);
        int n;
        model(o, cs, z, c, hv, pd);
        n = exp_q.size();
        op = o; cond = cs; flag_z = z; flag_c = c; hl = hv; push_data = pd;
        start = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            // per-cycle strobes, address, data, busy (also R13)
            check(busy && mem_rd == exp_q[k].rd && mem_wr == exp_q[k].wr && int_en == exp_q[k].ie
                  && (!(exp_q[k].rd || exp_q[k].wr) || mem_addr == exp_q[k].a)
                  && (!exp_q[k].wr || mem_wdata == exp_q[k].d),
                  req, $sformatf("cycle %0d {busy,rd,wr,ie,addr,wdata}", k),
                  {36'd0, busy, mem_rd, mem_wr, int_en, mem_addr, mem_wdata},
                  {36'd0, 1'b1, exp_q[k].rd, exp_q[k].wr, exp_q[k].ie, exp_q[k].a, exp_q[k].d});
            start = hold && (k < n - 1);
            if (hold) begin
                op = 3'd7; hl = 16'hDEAD; push_data = 16'hFFFF;   // R12 intruder
            end
        end
        @(negedge clk);
        start = 1'b0;
        check(!busy && !mem_rd && !mem_wr && pc == m_pc && sp == m_sp, req,
              "final {busy,rd,wr,pc,sp}",
              {29'd0, busy, mem_rd, mem_wr, pc, sp}, {32'd0, m_pc, m_sp});
        if (o == 3'd6)
            check(pop_data == m_pop, req, "pop_data", {48'd0, pop_data}, {48'd0, m_pop});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_pc = 16'h0100; m_sp = 16'hFFFE; m_pop = 16'h0000;
        @(negedge clk);
        check(pc == 16'h0100 && sp == 16'hFFFE && !busy && !mem_rd && !mem_wr, "R1",
              "reset {pc,sp,busy,rd,wr}", {29'd0, pc, sp, busy, mem_rd, mem_wr},
              {29'd0, 16'h0100, 16'hFFFE, 3'b000});
        run(3'd0, 3'd0, 0, 0, 0, 0, 0, "R2");            // taken absolute jump
        run(3'd0, 3'd1, 0, 0, 0, 0, 0, "R2 R4");         // carry-set condition false
        run(3'd1, 3'd2, 1, 0, 0, 0, 0, "R3 R4");         // relative taken on zero
        run(3'd1, 3'd4, 1, 0, 0, 0, 0, "R3 R4");         // relative not taken
        run(3'd2, 3'd3, 0, 0, 0, 0, 0, "R5 R4");         // call on carry clear
        run(3'd2, 3'd2, 0, 1, 0, 0, 0, "R6");            // call not taken
        run(3'd3, 3'd1, 0, 1, 0, 0, 0, "R7");            // return taken
        run(3'd3, 3'd2, 0, 0, 0, 0, 0, "R7");            // return not taken
        run(3'd5, 3'd0, 0, 0, 0, 16'hA5C3, 0, "R9");     // push
        run(3'd6, 3'd0, 0, 0, 0, 0, 0, "R10");           // pop
        run(3'd4, 3'd5, 0, 0, 0, 0, 0, "R8");            // reti with never-code
        run(3'd7, 3'd0, 0, 0, 16'h4321, 0, 0, "R11");    // jump to HL
        run(3'd0, 3'd6, 1, 1, 0, 0, 0, "R4");            // code 6 never taken
        run(3'd5, 3'd0, 0, 0, 0, 16'h1E2F, 1, "R12");    // start held while busy
        run(3'd2, 3'd0, 0, 0, 0, 0, 1, "R12 R5");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule